// File: doc/BRIEF.md
# Translated DMA Channel Engine

This block runs a small set of DMA channels that move bytes between a peripheral and memory. Each channel is set up by software through a register window: a mode word holding the enable and direction bits and three status flags, a byte count, and a logical address. A peripheral then asks for a transfer by naming a channel, a direction and a length.

Before anything moves, the engine clears the channel's status flags and checks the request against the channel setup. A disabled channel or a direction mismatch raises the channel's error flag and its bit in a shared non-maskable interrupt source word, and nothing is moved. Otherwise the length is clamped to the remaining count. Each logical address is translated in 4 KB pages. The engine fetches the page's frame word from a translation table in memory, located by a base register and sized in bytes by a limit register. Bytes then go one beat at a time over a request/grant memory port. Count and address are updated per byte, and the terminal-count flag is set on completion. A page outside the table raises the address error flag and stops the transfer.

Top module: `xlat_dma_engine`

## Requirements
- R1: After reset every channel's mode, count and address, the table base, the table limit and the interrupt source word read as zero, and `req_ready` is high.
- R2: Register window (byte offset, bits [2:0] ignored): 0x008 table base, 0x010 table limit, 0x018 interrupt source (read only, bit n for channel n); channel n sits at 0x100 + 32*n with mode at +0x08, count at +0x10, address at +0x18. Base and limit keep only bits [30:0] on write. A read returns data one cycle after `reg_rd`.
- R3: On acceptance of a request, mode bits 8 (terminal count), 9 (consistency error) and 10 (address error) of that channel are cleared before the request is evaluated.
- R4: If mode bit 0 (enable) is 0, or `req_to_dev` differs from mode bit 1 (1 = memory-to-device, 0 = device-to-memory), mode bit 9 and interrupt source bit n are set, no memory access is made, and `done` pulses with `done_ok` = 0.
- R5: The byte total moved is the smaller of `req_len` and the count register; count falls by one and address rises by one per byte moved; on completion bit 8 is set and `done` pulses with `done_ok` = 1 (also when zero bytes are due).
- R6: Logical page p = address >> 12 is translated by reading the 32-bit little-endian word at ((base + 8*p) & 0x7FFFFFFF); the physical byte address is (frame & ~0xFFF) | (address & 0xFFF). A new lookup is made whenever the address crosses a page boundary.
- R7: If p >= limit/8 (including limit = 0) or p >= MAX_ENTRIES, mode bit 10 is set, no further memory access is made, and `done` pulses with `done_ok` = 0.
- R8: Memory-to-device bytes appear on `dev_out_data` with `dev_out_valid`, in address order, one cycle after the read data returns; device-to-memory writes take `dev_in_data` on each granted write beat, marked by `dev_take`.
- R9: A memory request not yet granted keeps its address and direction unchanged in the next cycle.
- R10: A following request on the same channel continues at the address where the previous one stopped.
- R11: `done` is a single-cycle pulse; `req_ready` drops the cycle after a request is accepted, and no memory request is made while `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register window write strobe |
| reg_rd | input | 1 | Register window read strobe |
| reg_addr | input | 10 | Register window byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, registered |
| req_valid | input | 1 | Transfer request |
| req_ch | input | CH_W | Requested channel |
| req_to_dev | input | 1 | 1 = memory-to-device, 0 = device-to-memory |
| req_len | input | LEN_W | Requested byte length |
| req_ready | output | 1 | Engine idle, request accepted when valid |
| done | output | 1 | Transfer finished pulse |
| done_ok | output | 1 | Transfer finished without error |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_gnt | input | 1 | Memory grant for the current request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data (table word, or byte in [7:0]) |
| dev_in_data | input | 8 | Device byte for device-to-memory |
| dev_take | output | 1 | Device byte consumed |
| dev_out_valid | output | 1 | Device byte valid for memory-to-device |
| dev_out_data | output | 8 | Device byte out |

## Verification
The bench builds the engine with four channels and MAX_ENTRIES set to 4, so the table-size cap of R7 is reached with a table of only a few entries at small addresses, apart from the limit check. A 16 KB memory model with a grant that is withheld every third cycle lets page crossings, two distinct frames, frame low-bit masking, the clamp and a chained continuation be seen at small addresses, with stalled requests held under R9.

// File: rtl/xdma_pkg.sv
package xdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_LOOK, ST_TWAIT, ST_BEAT, ST_DWAIT, ST_DONE
  } xdma_st_e;

  localparam int MODE_EN   = 0;
  localparam int MODE_M2D  = 1;
  localparam int FLAG_LO   = 8;
  localparam int FLAG_HI   = 10;
  localparam logic [2:0] SET_TC  = 3'b001;
  localparam logic [2:0] SET_ERR = 3'b010;
  localparam logic [2:0] SET_ADR = 3'b100;
  localparam int ENTRY_SHIFT = 3;
endpackage

// File: rtl/xdma_xlate.sv
module xdma_xlate #(
  parameter int PAGE_BITS   = 12,
  parameter int MAX_ENTRIES = 512
) (
  input  logic [31:0] log_addr,
  input  logic [31:0] tbl_base,
  input  logic [31:0] tbl_limit,
  input  logic [31:0] frame,
  output logic [31:0] entry_addr,
  output logic [31:0] phys_addr,
  output logic        fault
);
  import xdma_pkg::*;

  logic [31:0] page;
  logic [31:0] n_entries;
  logic [31:0] ent_sum;
  logic        unused_bits;

  assign page       = log_addr >> PAGE_BITS;
  assign n_entries  = {1'b0, tbl_limit[30:0]} >> ENTRY_SHIFT;
  assign fault      = (page >= n_entries) || (page >= 32'(MAX_ENTRIES));
  assign ent_sum    = {1'b0, tbl_base[30:0]} + (page << ENTRY_SHIFT);
  assign entry_addr = {1'b0, ent_sum[30:0]};
  assign phys_addr  = {frame[31:PAGE_BITS], log_addr[PAGE_BITS-1:0]};
  assign unused_bits = ^{frame[PAGE_BITS-1:0], tbl_base[31], tbl_limit[31], ent_sum[31]};
endmodule

// File: rtl/xdma_regs.sv
module xdma_regs #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sw_wr,
  input  logic                    sw_rd,
  input  logic [9:0]              sw_addr,
  input  logic [31:0]             sw_wdata,
  output logic [31:0]             sw_rdata,
  input  logic [CH_W-1:0]         eng_ch,
  input  logic                    eng_clr,
  input  logic [2:0]              eng_set,
  input  logic                    eng_step,
  input  logic                    eng_nmi,
  output logic [NUM_CH-1:0][31:0] mode_o,
  output logic [NUM_CH-1:0][31:0] count_o,
  output logic [NUM_CH-1:0][31:0] addr_o,
  output logic [31:0]             base_o,
  output logic [31:0]             limit_o
);
  import xdma_pkg::*;

  logic              in_ch_area;
  logic [1:0]        idx;
  logic [NUM_CH-1:0] nmi_q;
  logic [31:0]       rd_val;
  logic              unused_low;

  assign in_ch_area = (sw_addr[9:8] == 2'b01);
  assign idx        = sw_addr[4:3];
  assign unused_low = ^sw_addr[2:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [31:0] mode_r, count_r, addr_r;
    logic        hit, mine;
    assign hit  = sw_wr && in_ch_area && (sw_addr[7:5] == 3'(g));
    assign mine = (eng_ch == CH_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        mode_r  <= '0;
        count_r <= '0;
        addr_r  <= '0;
      end else begin
        if (hit && idx == 2'd1) mode_r  <= sw_wdata;
        if (hit && idx == 2'd2) count_r <= sw_wdata;
        if (hit && idx == 2'd3) addr_r  <= sw_wdata;
        if (mine && eng_clr) mode_r[FLAG_HI:FLAG_LO] <= '0;
        if (mine && eng_set != '0)
          mode_r[FLAG_HI:FLAG_LO] <= mode_r[FLAG_HI:FLAG_LO] | eng_set;
        if (mine && eng_step) begin
          count_r <= count_r - 32'd1;
          addr_r  <= addr_r + 32'd1;
        end
      end
    end

    assign mode_o[g]  = mode_r;
    assign count_o[g] = count_r;
    assign addr_o[g]  = addr_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_o  <= '0;
      limit_o <= '0;
      nmi_q   <= '0;
    end else begin
      if (sw_wr && sw_addr[9:3] == 7'h01) base_o  <= {1'b0, sw_wdata[30:0]};
      if (sw_wr && sw_addr[9:3] == 7'h02) limit_o <= {1'b0, sw_wdata[30:0]};
      if (eng_nmi) nmi_q[eng_ch] <= 1'b1;
    end
  end

  always_comb begin
    rd_val = '0;
    case (sw_addr[9:3])
      7'h01: rd_val = base_o;
      7'h02: rd_val = limit_o;
      7'h03: rd_val = 32'(nmi_q);
      default: begin
        if (in_ch_area) begin
          for (int c = 0; c < NUM_CH; c++) begin
            if (sw_addr[7:5] == 3'(c)) begin
              case (idx)
                2'd1: rd_val = mode_o[c];
                2'd2: rd_val = count_o[c];
                2'd3: rd_val = addr_o[c];
                default: rd_val = '0;
              endcase
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) sw_rdata <= '0;
    else if (sw_rd) sw_rdata <= rd_val;
  end
endmodule

// File: rtl/xdma_ctrl.sv
module xdma_ctrl #(
  parameter int NUM_CH    = 4,
  parameter int CH_W      = 2,
  parameter int LEN_W     = 16,
  parameter int PAGE_BITS = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [CH_W-1:0]         req_ch,
  input  logic                    req_to_dev,
  input  logic [LEN_W-1:0]        req_len,
  output logic                    req_ready,
  output logic                    done,
  output logic                    done_ok,
  input  logic [NUM_CH-1:0][31:0] mode_i,
  input  logic [NUM_CH-1:0][31:0] count_i,
  input  logic [NUM_CH-1:0][31:0] addr_i,
  output logic [CH_W-1:0]         eng_ch,
  output logic                    eng_clr,
  output logic [2:0]              eng_set,
  output logic                    eng_step,
  output logic                    eng_nmi,
  output logic [31:0]             cur_addr,
  output logic [31:0]             frame_o,
  input  logic                    xl_fault,
  input  logic [31:0]             xl_entry,
  input  logic [31:0]             xl_phys,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [31:0]             mem_addr,
  output logic [7:0]              mem_wdata,
  input  logic                    mem_gnt,
  input  logic                    mem_rvalid,
  input  logic [31:0]             mem_rdata,
  input  logic [7:0]              dev_in_data,
  output logic                    dev_take,
  output logic                    dev_out_valid,
  output logic [7:0]              dev_out_data
);
  import xdma_pkg::*;

  xdma_st_e          st_q, st_d;
  logic [CH_W-1:0]   ch_q, ch_d;
  logic              dir_q, dir_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [31:0]       remain_q, remain_d;
  logic [31:0]       frame_q, frame_d;
  logic [31:0]       cur_mode, cur_count, eff_len;
  logic              fin, fin_ok, adv, out_v;
  logic              unused_mode;

  assign cur_mode    = mode_i[ch_q];
  assign cur_count   = count_i[ch_q];
  assign cur_addr    = addr_i[ch_q];
  assign frame_o     = frame_q;
  assign eff_len     = (cur_count < 32'(len_q)) ? cur_count : 32'(len_q);
  assign req_ready   = (st_q == ST_IDLE);
  assign eng_ch      = (st_q == ST_IDLE) ? req_ch : ch_q;
  assign mem_wdata   = dev_in_data;
  assign unused_mode = ^{cur_mode[31:2], cur_mode[MODE_EN]};

  always_comb begin
    st_d = st_q; ch_d = ch_q; dir_d = dir_q; len_d = len_q;
    remain_d = remain_q; frame_d = frame_q;
    fin = 1'b0; fin_ok = 1'b0; adv = 1'b0; out_v = 1'b0;
    eng_clr = 1'b0; eng_set = '0; eng_step = 1'b0; eng_nmi = 1'b0;
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = '0; dev_take = 1'b0;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        ch_d = req_ch; dir_d = req_to_dev; len_d = req_len;
        eng_clr = 1'b1;
        st_d = ST_CHECK;
      end
      ST_CHECK: begin
        if (!cur_mode[MODE_EN] || (cur_mode[MODE_M2D] != dir_q)) begin
          eng_set = SET_ERR; eng_nmi = 1'b1; fin = 1'b1;
        end else if (eff_len == '0) begin
          eng_set = SET_TC; fin = 1'b1; fin_ok = 1'b1;
        end else begin
          remain_d = eff_len;
          st_d = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (xl_fault) begin
          eng_set = SET_ADR; fin = 1'b1;
        end else begin
          mem_req = 1'b1; mem_addr = xl_entry;
          if (mem_gnt) st_d = ST_TWAIT;
        end
      end
      ST_TWAIT: if (mem_rvalid) begin
        frame_d = mem_rdata;
        st_d = ST_BEAT;
      end
      ST_BEAT: begin
        mem_req = 1'b1; mem_we = !dir_q; mem_addr = xl_phys;
        if (mem_gnt) begin
          if (!dir_q) begin
            dev_take = 1'b1; adv = 1'b1;
          end else begin
            st_d = ST_DWAIT;
          end
        end
      end
      ST_DWAIT: if (mem_rvalid) begin
        out_v = 1'b1; adv = 1'b1;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (adv) begin
      eng_step = 1'b1;
      remain_d = remain_q - 32'd1;
      if (remain_q == 32'd1) begin
        eng_set = SET_TC; fin = 1'b1; fin_ok = 1'b1;
      end else if (&cur_addr[PAGE_BITS-1:0]) begin
        st_d = ST_LOOK;
      end else begin
        st_d = ST_BEAT;
      end
    end
    if (fin) st_d = ST_DONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE; ch_q <= '0; dir_q <= 1'b0; len_q <= '0;
      remain_q <= '0; frame_q <= '0;
      done <= 1'b0; done_ok <= 1'b0;
      dev_out_valid <= 1'b0; dev_out_data <= '0;
    end else begin
      st_q <= st_d; ch_q <= ch_d; dir_q <= dir_d; len_q <= len_d;
      remain_q <= remain_d; frame_q <= frame_d;
      done <= fin; done_ok <= fin_ok;
      dev_out_valid <= out_v;
      if (out_v) dev_out_data <= mem_rdata[7:0];
    end
  end
endmodule

// File: rtl/xlat_dma_engine.sv
module xlat_dma_engine #(
  parameter int NUM_CH      = 4,
  parameter int LEN_W       = 16,
  parameter int PAGE_BITS   = 12,
  parameter int MAX_ENTRIES = 512,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [9:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             req_valid,
  input  logic [CH_W-1:0]  req_ch,
  input  logic             req_to_dev,
  input  logic [LEN_W-1:0] req_len,
  output logic             req_ready,
  output logic             done,
  output logic             done_ok,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic             mem_gnt,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata,
  input  logic [7:0]       dev_in_data,
  output logic             dev_take,
  output logic             dev_out_valid,
  output logic [7:0]       dev_out_data
);
  logic [NUM_CH-1:0][31:0] mode_w, count_w, addr_w;
  logic [31:0]             base_w, limit_w, cur_addr_w, frame_w;
  logic [31:0]             entry_w, phys_w;
  logic                    fault_w;
  logic [CH_W-1:0]         eng_ch_w;
  logic                    eng_clr_w, eng_step_w, eng_nmi_w;
  logic [2:0]              eng_set_w;

  xdma_regs #(.NUM_CH(NUM_CH), .CH_W(CH_W)) regs_i (
    .clk(clk), .rst(rst),
    .sw_wr(reg_wr), .sw_rd(reg_rd), .sw_addr(reg_addr),
    .sw_wdata(reg_wdata), .sw_rdata(reg_rdata),
    .eng_ch(eng_ch_w), .eng_clr(eng_clr_w), .eng_set(eng_set_w),
    .eng_step(eng_step_w), .eng_nmi(eng_nmi_w),
    .mode_o(mode_w), .count_o(count_w), .addr_o(addr_w),
    .base_o(base_w), .limit_o(limit_w)
  );

  xdma_xlate #(.PAGE_BITS(PAGE_BITS), .MAX_ENTRIES(MAX_ENTRIES)) xlate_i (
    .log_addr(cur_addr_w), .tbl_base(base_w), .tbl_limit(limit_w),
    .frame(frame_w), .entry_addr(entry_w), .phys_addr(phys_w), .fault(fault_w)
  );

  xdma_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W), .LEN_W(LEN_W), .PAGE_BITS(PAGE_BITS)) ctrl_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ch(req_ch), .req_to_dev(req_to_dev),
    .req_len(req_len), .req_ready(req_ready), .done(done), .done_ok(done_ok),
    .mode_i(mode_w), .count_i(count_w), .addr_i(addr_w),
    .eng_ch(eng_ch_w), .eng_clr(eng_clr_w), .eng_set(eng_set_w),
    .eng_step(eng_step_w), .eng_nmi(eng_nmi_w),
    .cur_addr(cur_addr_w), .frame_o(frame_w),
    .xl_fault(fault_w), .xl_entry(entry_w), .xl_phys(phys_w),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .dev_in_data(dev_in_data), .dev_take(dev_take),
    .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data)
  );
endmodule

// File: rtl/xdma_checker.sv
module xdma_checker (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic        done,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_gnt,
  input logic [31:0] mem_addr,
  input logic        mem_rvalid,
  input logic        dev_take,
  input logic        dev_out_valid
);
  assert_idle_no_mem_R11: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_hold_request_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_take_on_write_R8: assert property (@(posedge clk) disable iff (rst)
    dev_take |-> (mem_req && mem_we && mem_gnt));

  assert_out_follows_read_R8: assert property (@(posedge clk) disable iff (rst)
    dev_out_valid |-> $past(mem_rvalid));
endmodule

bind xlat_dma_engine xdma_checker chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt),
  .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .dev_take(dev_take),
  .dev_out_valid(dev_out_valid)
);

// File: tb/xlat_dma_engine_tb.sv
module xlat_dma_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0, rst = 1'b1;
  logic        reg_wr = 0, reg_rd = 0;
  logic [9:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        req_valid = 0, req_to_dev = 0;
  logic [1:0]  req_ch = 0;
  logic [15:0] req_len = 0;
  logic        req_ready, done, done_ok;
  logic        mem_req, mem_we, mem_gnt, mem_rvalid = 0;
  logic [31:0] mem_addr, mem_rdata = 0;
  logic [7:0]  mem_wdata, dev_in_data, dev_out_data;
  logic        dev_take, dev_out_valid;

  logic [7:0]  mem [0:16383];
  logic [31:0] gcnt = 0, acc_cnt = 0;
  logic [7:0]  take_cnt = 0;
  logic [7:0]  exp_q [$];
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_dma_engine #(.NUM_CH(NCH), .LEN_W(16), .PAGE_BITS(12), .MAX_ENTRIES(4)) dut_i (.*);

  assign mem_gnt     = (gcnt % 3) != 2;
  assign dev_in_data = 8'hA0 + take_cnt;

  always @(posedge clk) begin
    gcnt <= gcnt + 1;
    if (dev_take) take_cnt <= take_cnt + 8'd1;
    if (mem_req && mem_gnt) acc_cnt <= acc_cnt + 1;
    if (mem_req && mem_gnt && mem_we) mem[mem_addr[13:0]] <= mem_wdata;
    if (mem_req && mem_gnt && !mem_we) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= {mem[mem_addr[13:0]+14'd3], mem[mem_addr[13:0]+14'd2],
                     mem[mem_addr[13:0]+14'd1], mem[mem_addr[13:0]]};
    end else begin
      mem_rvalid <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && dev_out_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R8 unexpected byte", 32'(dev_out_data), 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(dev_out_data == e, "R8/R6 out byte", 32'(dev_out_data), 32'(e));
      end
    end
  end

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  task automatic push_bytes(input logic [31:0] phys, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(pat(phys + 32'(i)));
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  function automatic logic [9:0] choff(input int ch, input int idx);
    return 10'(32'h100 + ch*32 + idx*8);
  endfunction

  task automatic run(input int ch, input bit to_dev, input int len, output bit ok);
    @(negedge clk);
    req_valid = 1; req_ch = 2'(ch); req_to_dev = to_dev; req_len = 16'(len);
    @(negedge clk); req_valid = 0;
    while (!done) @(negedge clk);
    ok = done_ok;
    @(negedge clk);
  endtask

  task automatic expect_reg(input logic [9:0] a, input logic [31:0] e, input string req);
    logic [31:0] v;
    rd(a, v);
    check(v == e, req, v, e);
  endtask

  initial begin
    for (int i = 0; i < 16384; i++) mem[i] = pat(32'(i));
    {mem[3], mem[2], mem[1], mem[0]}     = 32'h0000_2000;
    {mem[11], mem[10], mem[9], mem[8]}   = 32'h0000_3000;
    {mem[19], mem[18], mem[17], mem[16]} = 32'h0000_1000;
    {mem[27], mem[26], mem[25], mem[24]} = 32'h0000_1ABC;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit ok;
    logic [31:0] a0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 1);
    expect_reg(choff(0,1), 0, "R1 mode");
    expect_reg(choff(0,2), 0, "R1 count");
    expect_reg(choff(3,3), 0, "R1 addr");
    expect_reg(10'h008, 0, "R1 base");
    expect_reg(10'h010, 0, "R1 limit");
    expect_reg(10'h018, 0, "R1 nmi");
    // R2 masking
    wr(10'h008, 32'h8000_0000);
    expect_reg(10'h008, 0, "R2 base bit31 masked");
    wr(10'h010, 32'h8000_0018);
    expect_reg(10'h010, 32'h18, "R2 limit masked");

    // R4 disabled channel
    wr(choff(3,2), 4); wr(choff(3,3), 0);
    a0 = acc_cnt;
    run(3, 1, 4, ok);
    check(ok == 0, "R4 disabled done_ok", 32'(ok), 0);
    check(acc_cnt == a0, "R4 no memory access", acc_cnt - a0, 0);
    expect_reg(choff(3,1), 32'h200, "R4 error flag");
    expect_reg(10'h018, 32'h8, "R4 nmi bit3");

    // R4 direction mismatch
    wr(choff(1,1), 32'h3);
    run(1, 0, 4, ok);
    check(ok == 0, "R4 mismatch done_ok", 32'(ok), 0);
    expect_reg(choff(1,1), 32'h203, "R4 mismatch flag");
    expect_reg(10'h018, 32'hA, "R4 nmi bit1");

    // R3/R5/R6 page crossing memory-to-device
    wr(choff(1,2), 8); wr(choff(1,3), 32'h0FFC);
    push_bytes(32'h2FFC, 4); push_bytes(32'h3000, 2);
    a0 = acc_cnt;
    run(1, 1, 6, ok);
    check(ok == 1, "R5 done_ok", 32'(ok), 1);
    check(acc_cnt - a0 == 8, "R6 two lookups plus six beats", acc_cnt - a0, 8);
    expect_reg(choff(1,1), 32'h103, "R3 flags cleared, TC set");
    expect_reg(choff(1,2), 2, "R5 count");
    expect_reg(choff(1,3), 32'h1002, "R5 address");

    // R10 chained, R5 clamp
    push_bytes(32'h3002, 2);
    run(1, 1, 10, ok);
    check(ok == 1, "R10 chained done_ok", 32'(ok), 1);
    expect_reg(choff(1,2), 0, "R5 clamp count");
    expect_reg(choff(1,3), 32'h1004, "R10 address continues");
    check(exp_q.size() == 0, "R8 all bytes seen", exp_q.size(), 0);

    // R5 zero count
    a0 = acc_cnt;
    run(1, 1, 3, ok);
    check(ok == 1 && acc_cnt == a0, "R5 zero-length", acc_cnt - a0, 0);
    expect_reg(choff(1,1), 32'h103, "R5 zero-length TC");

    // R8 device-to-memory
    wr(choff(2,1), 32'h1); wr(choff(2,2), 4); wr(choff(2,3), 32'h2010);
    run(2, 0, 4, ok);
    check(ok == 1, "R8 write done_ok", 32'(ok), 1);
    for (int i = 0; i < 4; i++)
      check(mem[16'h1010 + i] == 8'hA0 + 8'(i), "R8 written byte", 32'(mem[16'h1010+i]), 32'(8'hA0 + 8'(i)));
    expect_reg(choff(2,1), 32'h101, "R8 TC flag");
    expect_reg(choff(2,3), 32'h2014, "R8 address");

    // R7 limit fault
    wr(choff(0,1), 32'h3); wr(choff(0,2), 4); wr(choff(0,3), 32'h3000);
    a0 = acc_cnt;
    run(0, 1, 4, ok);
    check(ok == 0 && acc_cnt == a0, "R7 limit fault", acc_cnt - a0, 0);
    expect_reg(choff(0,1), 32'h403, "R7 address error flag");
    expect_reg(choff(0,2), 4, "R7 count untouched");

    // R6 frame low bits masked, now inside limit
    wr(10'h010, 64);
    wr(choff(0,3), 32'h3004);
    push_bytes(32'h1004, 1);
    run(0, 1, 1, ok);
    check(ok == 1, "R6 masked frame done_ok", 32'(ok), 1);
    expect_reg(choff(0,1), 32'h103, "R3 address flag cleared");

    // R7 entry cap
    wr(choff(0,3), 32'h4000);
    run(0, 1, 1, ok);
    check(ok == 0, "R7 entry cap", 32'(ok), 0);
    expect_reg(choff(0,1), 32'h403, "R7 cap flag");

    // R7 limit zero
    wr(10'h010, 0); wr(choff(0,3), 32'h0);
    run(0, 1, 1, ok);
    check(ok == 0, "R7 limit zero", 32'(ok), 0);
    check(exp_q.size() == 0, "R8 scoreboard empty", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule